// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block takes care of a DRAM's housekeeping timing. After reset it keeps every strobe line inactive through a power-up wait. It then asks the access controller for the bus a fixed number of times and runs one initialization refresh each time. When the last of these has finished, it raises its init-done flag.

After initialization an interval timer adds one owed refresh every `REF_INTERVAL` clock cycles. The interval is chosen so that all rows are covered within the retention period, which at default settings is about 15.6 µs at 100 MHz. Owed refreshes are counted up to a small ceiling, so a busy controller can hold off refreshes for a while without losing any of them. While a refresh is owed and the scheduler is idle, it raises a request. Once the controller grants the bus, the scheduler drives a full column-before-row refresh cycle by itself:
- all column strobes fall first;
- then all row strobes fall together;
- the column strobes return high;
- the row strobes return high and precharge.

After the precharge it releases the bus. Write enable stays high throughout, and addresses are never driven.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and for `PWRUP_CYC` cycles after reset, all strobes stay high, and `ref_req`, `drv_en` and `init_done` stay low.
- R2: After the power-up wait, exactly `INIT_REFS` refresh cycles run. `init_done` rises on the clock edge that ends the precharge of the last of them.
- R3: Once `init_done` is high, one refresh becomes owed every `REF_INTERVAL` cycles. The first becomes owed `REF_INTERVAL` cycles after `init_done` rises.
- R4: The owed count saturates at `OWED_MAX`, and further interval ticks are dropped. Each completed refresh after initialization lowers the count by one. A tick and a completion on the same edge leave it unchanged.
- R5: A refresh cycle starts only on an edge where the scheduler is idle with `ref_req` high and `ref_gnt` high. A grant without a request has no effect on any output. Once a cycle has started, it runs to completion whatever `ref_gnt` does.
- R6: A refresh cycle drives the strobes in this order:
  - all column strobes (`cas_n`, active low) go low for `CAS_SETUP` cycles while all row strobes (`ras_n`) stay high;
  - all row strobes then go low together for `RAS_LOW` cycles;
  - the column strobes stay low for the first `CAS_HOLD` of those cycles and then return high.
- R7: After the row strobes rise, all strobes stay high for `RAS_PRE` cycles while `drv_en` stays high. No new cycle can start during this window.
- R8: `we_n` is always high. `drv_en` is high exactly during the setup, row-low and precharge phases. All strobes are high whenever `drv_en` is low.
- R9: `ref_req` is low whenever `drv_en` is high. During normal operation it is high exactly when the scheduler is idle and at least one refresh is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Refresh request to the access controller |
| drv_en | output | 1 | Scheduler owns the strobe lines (busy) |
| ras_n | output | BANKS | Row strobes, active low |
| cas_n | output | BANKS | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Power-up wait and initialization refreshes complete |

## Verification
The bench withholds the grant long enough for many interval ticks to pass. A counter that did not saturate, or that wrapped, would then issue too many or too few back-to-back refreshes when the grant returns. It counts the refreshes that run before `init_done` rises, which catches an off-by-one in the init count or a flag raised one cycle early. It measures the spacing between refreshes under a constant grant, which exposes a timer that reloads one cycle off. Randomly toggled grants, including drops in the middle of a cycle and grants given with no request pending, show whether a cycle is ever cut short, started without a request, or given a shortened precharge or strobe phase.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [2:0] {
        RS_PWR   = 3'd0,
        RS_IDLE  = 3'd1,
        RS_SETUP = 3'd2,
        RS_ACT   = 3'd3,
        RS_PRE   = 3'd4
    } rfs_state_e;
endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_s;

    tick_s r_q, r_d;
    logic  wrap;

    always_comb begin
        r_d  = r_q;
        wrap = en && (r_q.cnt == CW'(INTERVAL - 1));
        if (en) begin
            r_d.cnt = wrap ? '0 : r_q.cnt + 1'b1;
        end
    end

    assign tick = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_tick_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);
endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
    parameter int MAXV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam int CW = $clog2(MAXV + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } owed_s;

    owed_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (inc && !dec) begin
            if (r_q.cnt != CW'(MAXV)) r_d.cnt = r_q.cnt + 1'b1;
        end else if (dec && !inc) begin
            if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    assign nonzero = (r_q.cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_owed_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(MAXV));
    assert_owed_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && nonzero) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfs_pkg::*;
#(
    parameter int PWRUP_CYC    = 20000,
    parameter int INIT_REFS    = 8,
    parameter int REF_INTERVAL = 1560,
    parameter int CAS_SETUP    = 1,
    parameter int CAS_HOLD     = 1,
    parameter int RAS_LOW      = 6,
    parameter int RAS_PRE      = 4,
    parameter int OWED_MAX     = 4,
    parameter int BANKS        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             drv_en,
    output logic [BANKS-1:0] ras_n,
    output logic [BANKS-1:0] cas_n,
    output logic             we_n,
    output logic             init_done
);
    localparam int PH_MAX = (RAS_LOW > RAS_PRE) ?
                            ((RAS_LOW > CAS_SETUP) ? RAS_LOW : CAS_SETUP) :
                            ((RAS_PRE > CAS_SETUP) ? RAS_PRE : CAS_SETUP);
    localparam int T_MAX  = (PWRUP_CYC > PH_MAX) ? PWRUP_CYC : PH_MAX;
    localparam int TW     = $clog2(T_MAX + 1);
    localparam int IW     = $clog2(INIT_REFS + 1);

    typedef struct packed {
        rfs_state_e    st;
        logic [TW-1:0] t;
        logic [IW-1:0] init_left;
        logic          init_done;
    } sched_s;

    sched_s r_q, r_d;
    logic   done_d;
    logic   tick;
    logic   owed_nz;
    logic   req_c;

    rfs_tick_gen #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.init_done),
        .tick  (tick)
    );

    rfs_owed_ctr #(.MAXV(OWED_MAX)) u_owed (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (done_d && r_q.init_done),
        .nonzero (owed_nz)
    );

    always_comb begin
        r_d    = r_q;
        done_d = 1'b0;
        req_c  = (r_q.st == RS_IDLE) &&
                 (r_q.init_done ? owed_nz : (r_q.init_left != '0));
        case (r_q.st)
            RS_PWR: begin
                if (r_q.t == TW'(PWRUP_CYC - 1)) begin
                    r_d.st = RS_IDLE;
                    r_d.t  = '0;
                end else begin
                    r_d.t = r_q.t + 1'b1;
                end
            end
            RS_IDLE: begin
                if (req_c && ref_gnt) begin
                    r_d.st = RS_SETUP;
                    r_d.t  = '0;
                end
            end
            RS_SETUP: begin
                if (r_q.t == TW'(CAS_SETUP - 1)) begin
                    r_d.st = RS_ACT;
                    r_d.t  = '0;
                end else begin
                    r_d.t = r_q.t + 1'b1;
                end
            end
            RS_ACT: begin
                if (r_q.t == TW'(RAS_LOW - 1)) begin
                    r_d.st = RS_PRE;
                    r_d.t  = '0;
                end else begin
                    r_d.t = r_q.t + 1'b1;
                end
            end
            RS_PRE: begin
                if (r_q.t == TW'(RAS_PRE - 1)) begin
                    r_d.st = RS_IDLE;
                    r_d.t  = '0;
                    done_d = 1'b1;
                end else begin
                    r_d.t = r_q.t + 1'b1;
                end
            end
            default: begin
                r_d.st = RS_IDLE;
                r_d.t  = '0;
            end
        endcase
        if (done_d && !r_q.init_done) begin
            r_d.init_left = r_q.init_left - 1'b1;
            if (r_q.init_left == IW'(1)) r_d.init_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= RS_PWR;
            r_q.t         <= '0;
            r_q.init_left <= IW'(INIT_REFS);
            r_q.init_done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ref_req   = req_c;
    assign drv_en    = (r_q.st == RS_SETUP) || (r_q.st == RS_ACT) || (r_q.st == RS_PRE);
    assign ras_n     = {BANKS{r_q.st != RS_ACT}};
    assign cas_n     = {BANKS{!((r_q.st == RS_SETUP) ||
                               ((r_q.st == RS_ACT) && (r_q.t < TW'(CAS_HOLD))))}};
    assign we_n      = 1'b1;
    assign init_done = r_q.init_done;

    assert_cas_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n[0]) |-> $past(cas_n == '0));
    assert_cas_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n[0]) |-> (cas_n == '0));
    assert_start_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> $past(ref_gnt && ref_req));
    assert_no_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> !ref_req);
    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> ((&ras_n) && (&cas_n)));
    assert_pre_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n[0]) |=> (ras_n[0] && drv_en));
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
    localparam int PWR  = 50;
    localparam int NINI = 8;
    localparam int INTV = 40;
    localparam int SU   = 1;
    localparam int CH   = 1;
    localparam int RL   = 6;
    localparam int RP   = 4;
    localparam int OMAX = 3;
    localparam int NB   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_gnt = 1'b0;
    logic          ref_req, drv_en, we_n, init_done;
    logic [NB-1:0] ras_n, cas_n;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .PWRUP_CYC(PWR), .INIT_REFS(NINI), .REF_INTERVAL(INTV),
        .CAS_SETUP(SU), .CAS_HOLD(CH), .RAS_LOW(RL), .RAS_PRE(RP),
        .OWED_MAX(OMAX), .BANKS(NB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .drv_en(drv_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .init_done(init_done)
    );

    int checks = 0;
    int errors = 0;

    // reference model: phase 0 wait, 1 idle, 2 column setup, 3 row low, 4 precharge
    int m_ph, m_t, m_ini, m_pend, m_tmr, m_starts;
    bit m_done;

    function automatic bit m_req();
        return (m_ph == 1) && (m_done ? (m_pend > 0) : (m_ini > 0));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_t = 0; m_ini = NINI; m_pend = 0; m_tmr = 0;
            m_done = 0; m_starts = 0;
        end else begin
            bit fin, tk, rq, was_done;
            rq       = m_req();
            was_done = m_done;
            fin      = (m_ph == 4) && (m_t == RP - 1);
            tk       = was_done && (m_tmr == INTV - 1);
            if (was_done) m_tmr = tk ? 0 : m_tmr + 1;
            if (was_done) begin
                if (fin) m_pend = m_pend - 1;
                if (tk) m_pend = m_pend + 1;
                if (m_pend > OMAX) m_pend = OMAX;
            end else if (fin) begin
                m_ini = m_ini - 1;
                if (m_ini == 0) m_done = 1;
            end
            case (m_ph)
                0: if (m_t == PWR - 1) begin m_ph = 1; m_t = 0; end else m_t++;
                1: if (rq && ref_gnt) begin m_ph = 2; m_t = 0; m_starts++; end
                2: if (m_t == SU - 1) begin m_ph = 3; m_t = 0; end else m_t++;
                3: if (m_t == RL - 1) begin m_ph = 4; m_t = 0; end else m_t++;
                4: if (m_t == RP - 1) begin m_ph = 1; m_t = 0; end else m_t++;
                default: m_ph = 1;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit casl, rasl, drv;
        casl = (m_ph == 2) || (m_ph == 3 && m_t < CH);
        rasl = (m_ph == 3);
        drv  = (m_ph >= 2);
        chk(ras_n == {NB{!rasl}}, "R6", "ras_n", ras_n, {NB{!rasl}});
        chk(cas_n == {NB{!casl}}, "R6", "cas_n", cas_n, {NB{!casl}});
        chk(drv_en == drv, "R8", "drv_en", drv_en, drv);
        chk(we_n == 1'b1, "R8", "we_n", we_n, 1);
        chk(ref_req == m_req(), "R9", "ref_req", ref_req, m_req());
        chk(init_done == m_done, "R2", "init_done", init_done, m_done);
        if (m_ph == 0) chk(!ref_req && !drv_en, "R1", "quiet in wait", ref_req, 0);
    endtask

    // edge bookkeeping for explicit checks
    int  falls = 0, last_fall = -1, cyc = 0;
    bit  prev_ras = 1'b1, prev_done = 1'b0, fall_post = 1'b0;
    bit  meas_spacing = 1'b0;

    task automatic step();
        @(negedge clk);
        cyc++;
        compare_all();
        if (prev_ras && !ras_n[0]) begin
            falls++;
            if (meas_spacing && fall_post)
                chk(cyc - last_fall == INTV, "R3", "refresh spacing", cyc - last_fall, INTV);
            if (init_done) fall_post = 1'b1;
            last_fall = cyc;
        end
        if (!prev_done && init_done)
            chk(falls == NINI, "R2", "init refresh count", falls, NINI);
        prev_ras  = ras_n[0];
        prev_done = init_done;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, dut_f;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ras_n == '1 && cas_n == '1, "R1", "strobes in reset", {ras_n, cas_n}, 8'hFF);
        chk(!ref_req && !drv_en && !init_done, "R1", "flags in reset",
            {ref_req, drv_en, init_done}, 0);
        // R5: grant during reset and power-up wait has no effect
        ref_gnt = 1'b1;
        rst_n = 1'b1;
        meas_spacing = 1'b1;
        repeat (600) step();
        meas_spacing = 1'b0;
        // R4: hold off grant across many ticks, then release
        ref_gnt = 1'b0;
        repeat (300) step();
        chk(ref_req == 1'b1, "R4", "request pending after hold-off", ref_req, 1);
        base  = m_starts;
        dut_f = falls;
        ref_gnt = 1'b1;
        repeat (12 * OMAX) step();
        chk(falls - dut_f == m_starts - base, "R4", "saturated backlog drained",
            falls - dut_f, m_starts - base);
        chk(falls - dut_f >= OMAX, "R4", "backlog at least the cap", falls - dut_f, OMAX);
        // R5, R7: random grant, including drops mid-cycle
        for (int i = 0; i < 3000; i++) begin
            ref_gnt = ($urandom_range(3, 0) != 0) ? ~ref_gnt : ref_gnt;
            step();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule